// File: doc/BRIEF.md
# Shared Buffer RAM Wait Controller

This block sits between a CPU system bus and a single-port message buffer RAM that is also used by a protocol controller. It decodes CPU address phases that fall inside the RAM window. It latches the RAM offset and keeps one CPU access outstanding until the RAM is free. The protocol controller always wins the RAM. When the CPU has an outstanding access while the controller holds the RAM, the block raises a wait. That wait removes the CPU clock enable and every system-bus clock enable, so the CPU and the bus freeze. The peripheral clock enable stays on, so the controller keeps working and eventually releases the RAM.

The wait acts as the back-pressure of the CPU request path, the same as a ready that is low. An address phase is accepted only in a cycle where the wait is low. An accepted access is served by a one-cycle go pulse once the RAM is free. The area flag that marks a captured address lives for one cycle only, right after the latch, so a stale flag can never produce a wait later. Address phases driven while a DMA master owns the bus are not decoded, and no wait is raised during DMA ownership. A DMA master runs from the peripheral clock, so stopping the bus clock under it would corrupt its transfer.

Top module: `sbw_ram_wait_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, bus_wait, area_sel and ram_cpu_go are 0, ram_owner is 0 (idle), and cpu_clk_en, every bit of bus_clk_en and periph_clk_en are 1.
- R2: An address phase (bus_ale=1) accepted with BASE <= bus_addr < BASE+SIZE raises area_sel in the next cycle only, with ram_cpu_addr = bus_addr - BASE. area_sel clears in the cycle after that unless another address phase is accepted. An address outside the window leaves area_sel at 0 and creates no access.
- R3: The controller has priority. ram_cpu_go is never 1 in a cycle where ctrl_busy is 1, and ram_owner reads 1 (controller) whenever ctrl_busy is 1, 2 (CPU) in a go cycle, and 0 otherwise.
- R4: An outstanding CPU access raises bus_wait in every cycle where ctrl_busy is 1 in the current or the previous cycle.
- R5: An outstanding CPU access gets ram_cpu_go in the first cycle where ctrl_busy was 0 in both the current and the previous cycle. bus_wait is 0 in that cycle, and the access is then retired.
- R6: Whenever bus_wait is 1, cpu_clk_en and all N_BUS bits of bus_clk_en are 0. Otherwise they are 1.
- R7: periph_clk_en is 1 in every cycle, whatever the wait state.
- R8: Once a CPU access has received its go pulse, bus_wait stays 0 even if the controller starts a new RAM access, until a new address phase is accepted. This includes the sequence CPU access, then DMA grant, then controller access.
- R9: While bus_dma_own is 1, address phases are not decoded and bus_wait is 0.
- R10: An address phase presented in a cycle where bus_wait is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ale | input | 1 | Address phase strobe on the system bus |
| bus_addr | input | ADDR_W | Address driven in the address phase |
| bus_dma_own | input | 1 | Bus ownership currently granted to the DMA master |
| ctrl_busy | input | 1 | Protocol controller is using the RAM |
| area_sel | output | 1 | One-cycle flag marking a freshly latched RAM address |
| ram_cpu_addr | output | OFF_W | Latched RAM offset of the CPU access |
| ram_cpu_go | output | 1 | CPU owns the RAM port this cycle |
| ram_owner | output | 2 | 0 idle, 1 controller, 2 CPU |
| bus_wait | output | 1 | CPU/bus wait request |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | N_BUS | System bus clock enables |
| periph_clk_en | output | 1 | Peripheral clock enable |

## Verification
The hardest state to reach is the hazard sequence. A CPU RAM access completes, ownership passes to the DMA master, and the controller then claims the RAM while the DMA master drives an address phase inside the RAM window. A block that keeps a stale area flag would freeze the bus clock at that point. A directed sequence builds this order of events and checks that the clock enables stay high. Seeded random traffic mixes bursty controller activity with DMA ownership and in-window addresses. This reaches the cases where an address phase lands during a wait and where the controller releases the RAM for a single cycle.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_CTRL = 2'd1,
    OWN_CPU  = 2'd2
  } ram_owner_e;
endpackage

// File: rtl/sbw_area_decode.sv
module sbw_area_decode #(
  parameter int ADDR_W = 16,
  parameter int BASE   = 'h3C00,
  parameter int SIZE   = 256,
  localparam int OFF_W = (SIZE > 1) ? $clog2(SIZE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dma_own_i,
  input  logic              wait_i,
  output logic              hit_o,
  output logic              area_q_o,
  output logic [OFF_W-1:0]  off_q_o
);
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(BASE + SIZE);

  logic [ADDR_W:0] addr_ext;
  logic [ADDR_W:0] addr_rel;
  logic            in_window;

  assign addr_ext  = {1'b0, addr_i};
  assign addr_rel  = addr_ext - WIN_LO;
  assign in_window = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
  // Accept only CPU-owned address phases that are not frozen by a wait.
  assign hit_o     = ale_i && in_window && !dma_own_i && !wait_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      area_q_o <= 1'b0;
      off_q_o  <= '0;
    end else begin
      // Flag lives only for the cycle right after the latch.
      area_q_o <= hit_o;
      if (hit_o) off_q_o <= addr_rel[OFF_W-1:0];
    end
  end
endmodule

// File: rtl/sbw_arbiter.sv
module sbw_arbiter
  import sbw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_i,
  input  logic       ctrl_busy_i,
  input  logic       dma_own_i,
  output logic       wait_o,
  output logic       go_o,
  output ram_owner_e owner_o
);
  logic busy_s;
  logic pend_q;
  logic busy_any;

  assign busy_any = ctrl_busy_i || busy_s;
  assign wait_o   = pend_q && !dma_own_i && busy_any;
  assign go_o     = pend_q && !dma_own_i && !busy_any;

  always_comb begin
    if (ctrl_busy_i)  owner_o = OWN_CTRL;
    else if (go_o)    owner_o = OWN_CPU;
    else              owner_o = OWN_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_s <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      busy_s <= ctrl_busy_i;
      if (hit_i)     pend_q <= 1'b1;
      else if (go_o) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sbw_clken.sv
module sbw_clken #(
  parameter int N_BUS = 2
) (
  input  logic             wait_i,
  output logic             cpu_ce_o,
  output logic [N_BUS-1:0] bus_ce_o,
  output logic             periph_ce_o
);
  assign cpu_ce_o    = !wait_i;
  assign periph_ce_o = 1'b1;
  for (genvar g = 0; g < N_BUS; g++) begin : g_bus
    assign bus_ce_o[g] = !wait_i;
  end
endmodule

// File: rtl/sbw_ram_wait_ctrl.sv
module sbw_ram_wait_ctrl
  import sbw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BASE   = 'h3C00,
  parameter int SIZE   = 256,
  parameter int N_BUS  = 2,
  localparam int OFF_W = (SIZE > 1) ? $clog2(SIZE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ale,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_dma_own,
  input  logic              ctrl_busy,
  output logic              area_sel,
  output logic [OFF_W-1:0]  ram_cpu_addr,
  output logic              ram_cpu_go,
  output logic [1:0]        ram_owner,
  output logic              bus_wait,
  output logic              cpu_clk_en,
  output logic [N_BUS-1:0]  bus_clk_en,
  output logic              periph_clk_en
);
  logic       hit;
  ram_owner_e owner;

  sbw_area_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .SIZE(SIZE)) u_dec (
    .clk(clk), .rst_n(rst_n), .ale_i(bus_ale), .addr_i(bus_addr),
    .dma_own_i(bus_dma_own), .wait_i(bus_wait), .hit_o(hit),
    .area_q_o(area_sel), .off_q_o(ram_cpu_addr)
  );

  sbw_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .ctrl_busy_i(ctrl_busy),
    .dma_own_i(bus_dma_own), .wait_o(bus_wait), .go_o(ram_cpu_go),
    .owner_o(owner)
  );

  assign ram_owner = owner;

  sbw_clken #(.N_BUS(N_BUS)) u_ce (
    .wait_i(bus_wait), .cpu_ce_o(cpu_clk_en), .bus_ce_o(bus_clk_en),
    .periph_ce_o(periph_clk_en)
  );
endmodule

// File: rtl/sbw_ram_wait_ctrl_chk.sv
module sbw_ram_wait_ctrl_chk #(
  parameter int N_BUS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_ale,
  input logic             bus_dma_own,
  input logic             ctrl_busy,
  input logic             area_sel,
  input logic             ram_cpu_go,
  input logic             bus_wait,
  input logic             cpu_clk_en,
  input logic [N_BUS-1:0] bus_clk_en
);
  AST_GO_YIELDS_TO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_busy |-> !ram_cpu_go); // R3
  AST_AREA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (area_sel && !bus_ale) |=> !area_sel); // R2
  AST_WAIT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> (!cpu_clk_en && (bus_clk_en == '0))); // R6
  AST_NO_DMA_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dma_own |-> !bus_wait); // R9
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_busy && $past(!ctrl_busy)) |-> !bus_wait); // R5
  AST_NO_STALE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cpu_go && !bus_ale) |=> !bus_wait); // R8
endmodule

bind sbw_ram_wait_ctrl sbw_ram_wait_ctrl_chk #(.N_BUS(N_BUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ale(bus_ale), .bus_dma_own(bus_dma_own),
  .ctrl_busy(ctrl_busy), .area_sel(area_sel), .ram_cpu_go(ram_cpu_go),
  .bus_wait(bus_wait), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en)
);

// File: tb/sim_sbw_ram_wait_ctrl.sv
`timescale 1ns/1ps
module sim_sbw_ram_wait_ctrl;
  localparam int ADDR_W = 16;
  localparam int BASE   = 'h3C00;
  localparam int SIZE   = 256;
  localparam int N_BUS  = 2;
  localparam int OFF_W  = $clog2(SIZE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ale = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_dma_own = 1'b0;
  logic ctrl_busy = 1'b0;
  logic area_sel, ram_cpu_go, bus_wait, cpu_clk_en, periph_clk_en;
  logic [OFF_W-1:0] ram_cpu_addr;
  logic [1:0] ram_owner;
  logic [N_BUS-1:0] bus_clk_en;

  int errors = 0;
  int checks = 0;

  // Requirement-level model state
  bit m_pend = 0, m_prev_busy = 0, m_area = 0;
  int m_off = 0;

  always #2.5 clk = ~clk;

  sbw_ram_wait_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE), .SIZE(SIZE), .N_BUS(N_BUS)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_ale(bus_ale), .bus_addr(bus_addr),
    .bus_dma_own(bus_dma_own), .ctrl_busy(ctrl_busy), .area_sel(area_sel),
    .ram_cpu_addr(ram_cpu_addr), .ram_cpu_go(ram_cpu_go), .ram_owner(ram_owner),
    .bus_wait(bus_wait), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
    .periph_clk_en(periph_clk_en)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit in_win(int a);
    return (a >= BASE) && (a < BASE + SIZE);
  endfunction

  // Drive one cycle, compare against the model just before the edge, update model.
  task automatic step(bit ale, int addr, bit dma, bit busy);
    bit e_wait, e_go, hit;
    int e_own;
    @(negedge clk);
    bus_ale = ale; bus_addr = addr[ADDR_W-1:0]; bus_dma_own = dma; ctrl_busy = busy;
    #2;
    e_wait = m_pend && !dma && (busy || m_prev_busy);
    e_go   = m_pend && !dma && !busy && !m_prev_busy;
    e_own  = busy ? 1 : (e_go ? 2 : 0);
    chk("R4/R9 bus_wait", bus_wait, e_wait);
    chk("R5 ram_cpu_go", ram_cpu_go, e_go);
    chk("R3 ram_owner", ram_owner, e_own);
    chk("R2 area_sel", area_sel, m_area);
    if (m_area) chk("R2 ram_cpu_addr", ram_cpu_addr, m_off);
    chk("R6 cpu_clk_en", cpu_clk_en, !e_wait);
    chk("R6 bus_clk_en", bus_clk_en, e_wait ? 0 : (1 << N_BUS) - 1);
    chk("R7 periph_clk_en", periph_clk_en, 1);
    hit = ale && !dma && in_win(addr) && !e_wait;   // R10: ignored during wait
    m_area = hit;
    if (hit) begin m_pend = 1; m_off = addr - BASE; end
    else if (e_go) m_pend = 0;
    m_prev_busy = busy;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #2;
    chk("R1 bus_wait reset", bus_wait, 0);
    chk("R1 area_sel reset", area_sel, 0);
    chk("R1 go reset", ram_cpu_go, 0);
    chk("R1 owner reset", ram_owner, 0);
    chk("R1 cpu_clk_en reset", cpu_clk_en, 1);
    chk("R1 bus_clk_en reset", bus_clk_en, (1 << N_BUS) - 1);
    chk("R1 periph_clk_en reset", periph_clk_en, 1);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0);

    // R2: miss and in-window access with free RAM
    step(1, BASE - 1, 0, 0);
    step(0, 0, 0, 0);
    step(1, BASE + 8'h5A, 0, 0);
    step(0, 0, 0, 0);  // area + go
    step(0, 0, 0, 0);  // area cleared

    // R4/R5: access while controller busy, released after one sampled cycle
    step(1, BASE + 3, 0, 1);
    step(0, 0, 0, 1);
    step(1, BASE + 9, 0, 1);   // R10 ignored during wait
    step(0, 0, 0, 0);          // still waiting (busy previous cycle)
    step(0, 0, 0, 0);          // go
    step(0, 0, 0, 0);

    // R8 hazard: CPU access, DMA grant, controller access
    step(1, BASE + 17, 0, 0);
    step(0, 0, 0, 0);          // go
    step(0, 0, 1, 0);          // DMA owns bus
    step(1, BASE + 20, 1, 1);  // R9 DMA address in window, controller busy
    step(0, 0, 1, 1);
    #0;
    chk("R8 cpu_clk_en after hazard", cpu_clk_en, 1);
    chk("R8 bus_clk_en after hazard", bus_clk_en, (1 << N_BUS) - 1);
    chk("R9 area_sel after DMA phase", area_sel, 0);
    step(0, 0, 0, 1);          // DMA returns, controller still busy: no wait
    #0;
    chk("R8 no wait after ownership returns", bus_wait, 0);
    step(0, 0, 0, 0);

    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      bit ale, dma, busy;
      int addr;
      ale  = ($urandom % 3) == 0;
      addr = (($urandom % 5) < 3) ? BASE + ($urandom % SIZE) : ($urandom % 65536);
      dma  = ($urandom % 6) == 0;
      busy = (($urandom % 5) == 0) ? !ctrl_busy : ctrl_busy;
      step(ale, addr, dma, busy);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule